// File: doc/BRIEF.md
# Push-Button Volume Step Controller

This block converts three active-low push buttons (volume up, volume down, mute) and an active-low standby input into a stereo attenuation index for a downstream apply stage. That apply stage performs the actual wiper change. All timing comes from a one-millisecond tick input, so the block runs from any system clock. Each button input passes through a two-flop synchronizer. A press must then stay stable for a debounce window before it counts.

An accepted press moves a saturating position register by one step. A press held long enough repeats the step, first at a slow rate and then at a faster one. Every accepted command opens a lockout window, and any command that would complete inside that window is dropped. Pressing more than one button at a time cancels everything until all buttons have been released.

The mute button toggles between a dedicated mute code and the level that was held before muting. Standby forces the output to the mute code. When standby ends, the output returns to the level that was held before standby. Whenever the output index changes, a one-cycle request strobe accompanies the new value.

Top module: `vol_step_ctrl`

## Requirements
- R1: `level_o` carries index 0 (loudest) through 31 (quietest) in steps of 2 dB or more. The value 32 is the mute code, and `level_o` never exceeds 32.
- R2: After reset, `level_o` is 10 and `req_o` is low.
- R3: A button counts only after its synchronized level has stayed low for DEB_MS ticks. Shorter pulses do nothing. An accepted up press lowers the index by one, and an accepted down press raises it by one.
- R4: After any accepted command, no command is accepted for LOCK_MS ticks. A press whose debounce completes inside that window is discarded, and nothing more happens until that button is released.
- R5: While up or down stays held, the step repeats. The first repeat comes HOLD_MS ticks after acceptance. Further repeats come every SLOW_MS ticks until HOLD_MS+SLOW_SPAN_MS ticks have elapsed, and every FAST_MS ticks after that. A held mute button does not repeat.
- R6: The index saturates at both ends and never wraps. Up at 0 and down at 31 leave it unchanged.
- R7: The first accepted mute sets the index to 32. The next accepted mute restores the index that was held just before muting.
- R8: If two or more buttons are seen low at the same time, no command is issued, and nothing is accepted until all buttons are released.
- R9: While standby is low, `level_o` is 32 and button commands are ignored. When standby is released, `level_o` returns to the index that was held before standby.
- R10: While muted, up and down commands leave the index at 32.
- R11: `req_o` is high for exactly the cycles in which `level_o` has just changed. This includes every repeat step, and excludes any step that is blocked by saturation.
- R12: The debounce, lockout and repeat timers advance only on cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| up_ni | input | 1 | Volume up button, active low, asynchronous |
| dn_ni | input | 1 | Volume down button, active low, asynchronous |
| mute_ni | input | 1 | Mute toggle button, active low, asynchronous |
| stby_ni | input | 1 | Standby request, active low, asynchronous |
| level_o | output | 6 | Requested attenuation index (0 to 31, or 32 for mute) |
| req_o | output | 1 | One-cycle strobe marking a new `level_o` |

## Verification
The bench measures the spacing between strobes during a long hold, in ticks. A repeat engine with an off-by-one error, or one that switches to the fast rate at the wrong time, shows the wrong intervals. It re-presses a button right after a command is accepted. A missing lockout would then produce a second step. It sweeps the index into both ends. A design that wraps would jump to the far end, and a design that pulses `req_o` on blocked steps would show extra strobes. Chorded presses, presses during mute, presses during standby and presses with the tick stopped must all leave the level and the strobe count untouched. A design that fails to restore the saved level shows the wrong index after unmute or after standby release.

// File: rtl/vol_pkg.sv
package vol_pkg;
  typedef enum logic [1:0] {CMD_NONE, CMD_UP, CMD_DN, CMD_MUTE} vol_cmd_e;
  typedef enum logic [1:0] {F_IDLE, F_DEB, F_HELD, F_WAIT} flt_state_e;
endpackage

// File: rtl/vol_sync.sv
module vol_sync #(
  parameter int   W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL;
        s2 <= RST_VAL;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/vol_key_filter.sv
module vol_key_filter
  import vol_pkg::*;
#(
  parameter int DEB_MS       = 50,
  parameter int LOCK_MS      = 40,
  parameter int HOLD_MS      = 1000,
  parameter int SLOW_MS      = 250,
  parameter int SLOW_SPAN_MS = 4000,
  parameter int FAST_MS      = 125
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic [2:0] press_i,  // bit0 up, bit1 down, bit2 mute; active high
  output vol_cmd_e cmd_o
);
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EL_MAX = HOLD_MS + SLOW_SPAN_MS;
  localparam int BIG    = imax(imax(EL_MAX, LOCK_MS), imax(DEB_MS, imax(SLOW_MS, FAST_MS)));
  localparam int CW     = $clog2(BIG + 1);
  localparam logic [CW-1:0] DEB_LAST = CW'(DEB_MS - 1);
  localparam logic [CW-1:0] LOCK_C   = CW'(LOCK_MS);
  localparam logic [CW-1:0] HOLD_C   = CW'(HOLD_MS);
  localparam logic [CW-1:0] SLOW_C   = CW'(SLOW_MS);
  localparam logic [CW-1:0] FAST_C   = CW'(FAST_MS);
  localparam logic [CW-1:0] EL_TOP   = CW'(EL_MAX);
  localparam logic [CW-1:0] EL_PRE   = CW'(EL_MAX - 1);
  localparam logic [CW-1:0] ONE_C    = CW'(1);

  flt_state_e   st;
  logic [2:0]   sel;
  logic [CW-1:0] deb_cnt, lock_cnt, el_cnt, gap_cnt;

  logic multi, any, same;
  assign any   = |press_i;
  assign multi = (press_i & (press_i - 3'd1)) != 3'd0;
  assign same  = (press_i == sel);

  function automatic vol_cmd_e to_cmd(input logic [2:0] s);
    if (s[0]) return CMD_UP;
    if (s[1]) return CMD_DN;
    return CMD_MUTE;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= F_IDLE;
      sel      <= '0;
      deb_cnt  <= '0;
      lock_cnt <= '0;
      el_cnt   <= '0;
      gap_cnt  <= '0;
      cmd_o    <= CMD_NONE;
    end else begin
      cmd_o <= CMD_NONE;
      if (tick_i && lock_cnt != '0) lock_cnt <= lock_cnt - ONE_C;
      unique case (st)
        F_IDLE: begin
          if (multi) st <= F_WAIT;
          else if (any) begin
            st      <= F_DEB;
            sel     <= press_i;
            deb_cnt <= '0;
          end
        end
        F_DEB: begin
          if (!same) st <= any ? F_WAIT : F_IDLE;
          else if (tick_i) begin
            if (deb_cnt == DEB_LAST) begin
              if (lock_cnt == '0) begin
                cmd_o    <= to_cmd(sel);
                lock_cnt <= LOCK_C;
                st       <= F_HELD;
                el_cnt   <= '0;
                gap_cnt  <= HOLD_C;
              end else begin
                st <= F_WAIT;  // completed inside lockout: dropped
              end
            end else begin
              deb_cnt <= deb_cnt + ONE_C;
            end
          end
        end
        F_HELD: begin
          if (!same) st <= any ? F_WAIT : F_IDLE;
          else if (tick_i && !sel[2]) begin
            if (el_cnt != EL_TOP) el_cnt <= el_cnt + ONE_C;
            if (gap_cnt == ONE_C) begin
              if (lock_cnt == '0) begin
                cmd_o    <= to_cmd(sel);
                lock_cnt <= LOCK_C;
              end
              gap_cnt <= (el_cnt < EL_PRE) ? SLOW_C : FAST_C;
            end else begin
              gap_cnt <= gap_cnt - ONE_C;
            end
          end
        end
        default: begin
          if (!any) st <= F_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/vol_level_reg.sv
module vol_level_reg
  import vol_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int MAX_IDX = 31,
  parameter int RST_IDX = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  vol_cmd_e         cmd_i,
  input  logic             stby_i,
  output logic [IDX_W-1:0] level_o,
  output logic             req_o
);
  localparam logic [IDX_W-1:0] MAX_V  = IDX_W'(MAX_IDX);
  localparam logic [IDX_W-1:0] MUTE_V = IDX_W'(MAX_IDX + 1);
  localparam logic [IDX_W-1:0] RST_V  = IDX_W'(RST_IDX);
  localparam logic [IDX_W-1:0] ONE_V  = IDX_W'(1);

  logic [IDX_W-1:0] lvl_q, lvl_d, sav_q, sav_d, out_d;

  always_comb begin
    lvl_d = lvl_q;
    sav_d = sav_q;
    if (!stby_i) begin
      unique case (cmd_i)
        CMD_UP:   if (lvl_q != MUTE_V && lvl_q != '0)    lvl_d = lvl_q - ONE_V;
        CMD_DN:   if (lvl_q != MUTE_V && lvl_q != MAX_V) lvl_d = lvl_q + ONE_V;
        CMD_MUTE: begin
          if (lvl_q == MUTE_V) lvl_d = sav_q;
          else begin
            sav_d = lvl_q;
            lvl_d = MUTE_V;
          end
        end
        default: ;
      endcase
    end
    out_d = stby_i ? MUTE_V : lvl_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= RST_V;
      sav_q   <= RST_V;
      level_o <= RST_V;
      req_o   <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      sav_q   <= sav_d;
      level_o <= out_d;
      req_o   <= (out_d != level_o);
    end
  end
endmodule

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl
  import vol_pkg::*;
#(
  parameter int MAX_IDX      = 31,
  parameter int RST_IDX      = 10,
  parameter int DEB_MS       = 50,
  parameter int LOCK_MS      = 40,
  parameter int HOLD_MS      = 1000,
  parameter int SLOW_MS      = 250,
  parameter int SLOW_SPAN_MS = 4000,
  parameter int FAST_MS      = 125,
  localparam int IDX_W       = $clog2(MAX_IDX + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             up_ni,
  input  logic             dn_ni,
  input  logic             mute_ni,
  input  logic             stby_ni,
  output logic [IDX_W-1:0] level_o,
  output logic             req_o
);
  logic [2:0] btn_s;
  logic [2:0] press_s;
  logic       stby_s;
  logic       stby_act;
  logic       cmd_fire;
  vol_cmd_e   cmd;

  vol_sync #(.W(3), .RST_VAL(1'b1)) u_btn_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mute_ni, dn_ni, up_ni}),
    .q_o   (btn_s)
  );

  vol_sync #(.W(1), .RST_VAL(1'b1)) u_stby_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stby_ni),
    .q_o   (stby_s)
  );

  assign press_s  = ~btn_s;
  assign stby_act = ~stby_s;
  assign cmd_fire = (cmd != CMD_NONE);

  vol_key_filter #(
    .DEB_MS      (DEB_MS),
    .LOCK_MS     (LOCK_MS),
    .HOLD_MS     (HOLD_MS),
    .SLOW_MS     (SLOW_MS),
    .SLOW_SPAN_MS(SLOW_SPAN_MS),
    .FAST_MS     (FAST_MS)
  ) u_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .press_i(press_s),
    .cmd_o  (cmd)
  );

  vol_level_reg #(
    .IDX_W  (IDX_W),
    .MAX_IDX(MAX_IDX),
    .RST_IDX(RST_IDX)
  ) u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .stby_i (stby_act),
    .level_o(level_o),
    .req_o  (req_o)
  );
endmodule

// File: rtl/vol_step_ctrl_chk.sv
module vol_step_ctrl_chk #(
  parameter int MAX_IDX = 31,
  parameter int IDX_W   = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] level_o,
  input logic             req_o,
  input logic [2:0]       press_i,
  input logic             stby_i,
  input logic             cmd_fire_i
);
  localparam logic [IDX_W-1:0] MAX_V  = IDX_W'(MAX_IDX);
  localparam logic [IDX_W-1:0] MUTE_V = IDX_W'(MAX_IDX + 1);

  AST_LEVEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= MUTE_V);  // R1

  AST_STEP_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(level_o) <= MAX_V && level_o <= MAX_V) |->
      (level_o == $past(level_o) + 1'b1 || $past(level_o) == level_o + 1'b1));  // R6

  AST_REQ_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o == (level_o != $past(level_o)));  // R11

  AST_STBY_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stby_i) |-> level_o == MUTE_V);  // R9

  AST_CHORD_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(press_i) > 1) |=> !cmd_fire_i);  // R8

  AST_LOCKOUT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fire_i |=> !cmd_fire_i);  // R4
endmodule

bind vol_step_ctrl vol_step_ctrl_chk #(.MAX_IDX(MAX_IDX), .IDX_W(IDX_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .level_o   (level_o),
  .req_o     (req_o),
  .press_i   (press_s),
  .stby_i    (stby_act),
  .cmd_fire_i(cmd_fire)
);

// File: tb/vol_step_ctrl_bench.sv
module vol_step_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic up_n = 1'b1, dn_n = 1'b1, mute_n = 1'b1, stby_n = 1'b1;
  logic [5:0] level;
  logic req;

  int n_chk = 0, n_bad = 0, cyc = 0, stb_cnt = 0;
  int stb_t [0:63];
  bit done = 0;

  always #4 clk = ~clk;

  vol_step_ctrl #(
    .DEB_MS(4), .LOCK_MS(12), .HOLD_MS(40), .SLOW_MS(20),
    .SLOW_SPAN_MS(60), .FAST_MS(14)
  ) u_vol_step_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .up_ni(up_n), .dn_ni(dn_n), .mute_ni(mute_n), .stby_ni(stby_n),
    .level_o(level), .req_o(req)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n && req) begin
      if (stb_cnt < 64) stb_t[stb_cnt] = cyc;
      stb_cnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input bit u, input bit d, input bit m, input int n);
    up_n = ~u; dn_n = ~d; mute_n = ~m;
    wait_cyc(n);
    up_n = 1'b1; dn_n = 1'b1; mute_n = 1'b1;
    wait_cyc(24);
  endtask

  task automatic t_reset;
    wait_cyc(5);
    chk("R2 level after reset", level, 10);
    chk("R2 no strobe after reset", stb_cnt, 0);
  endtask

  task automatic t_debounce;
    stb_cnt = 0;
    press(1, 0, 0, 3);
    chk("R3 short pulse ignored", stb_cnt, 0);
    chk("R3 level after glitch", level, 10);
    press(1, 0, 0, 10);
    chk("R3 up lowers index", level, 9);
    chk("R11 one strobe per step", stb_cnt, 1);
    press(0, 1, 0, 10);
    chk("R3 down raises index", level, 10);
  endtask

  task automatic t_lockout;
    stb_cnt = 0;
    up_n = 1'b0; wait_cyc(9);
    up_n = 1'b1; wait_cyc(1);
    up_n = 1'b0; wait_cyc(9);
    up_n = 1'b1; wait_cyc(24);
    chk("R4 re-press in lockout dropped", stb_cnt, 1);
    chk("R4 level after lockout", level, 9);
    press(0, 1, 0, 10);
    chk("R4 accepted after lockout", level, 10);
  endtask

  task automatic t_repeat;
    int exp_gap [6] = '{40, 20, 20, 20, 14, 14};
    stb_cnt = 0;
    dn_n = 1'b0;
    while (stb_cnt == 0) @(negedge clk);
    wait_cyc(135);
    dn_n = 1'b1;
    wait_cyc(24);
    chk("R5 repeat strobe count", stb_cnt, 7);
    chk("R5 level after repeat", level, 17);
    for (int i = 1; i < 7; i++) chk("R5 repeat interval", stb_t[i] - stb_t[i-1], exp_gap[i-1]);
  endtask

  task automatic t_saturate;
    stb_cnt = 0;
    press(0, 1, 0, 700);
    chk("R6 bottom saturates", level, 31);
    chk("R11 no strobe on blocked step", stb_cnt, 14);
    stb_cnt = 0;
    press(1, 0, 0, 600);
    chk("R6 top saturates", level, 0);
    chk("R11 up sweep strobes", stb_cnt, 31);
    stb_cnt = 0;
    press(1, 0, 0, 10);
    chk("R6 up at 0 no change", level, 0);
    chk("R6 up at 0 no strobe", stb_cnt, 0);
  endtask

  task automatic t_mute;
    press(0, 1, 0, 10);
    stb_cnt = 0;
    press(0, 0, 1, 100);
    chk("R7 mute code", level, 32);
    chk("R5 held mute does not repeat", stb_cnt, 1);
    press(1, 0, 0, 10);
    chk("R10 up ignored while muted", level, 32);
    press(0, 1, 0, 10);
    chk("R10 down ignored while muted", level, 32);
    chk("R10 no strobe while muted", stb_cnt, 1);
    press(0, 0, 1, 10);
    chk("R7 unmute restores", level, 1);
  endtask

  task automatic t_chord;
    stb_cnt = 0;
    press(1, 1, 0, 20);
    chk("R8 up+down ignored", stb_cnt, 0);
    up_n = 1'b0; wait_cyc(3);
    dn_n = 1'b0; wait_cyc(20);
    up_n = 1'b1; wait_cyc(20);
    dn_n = 1'b1; wait_cyc(24);
    chk("R8 staggered chord ignored", stb_cnt, 0);
    press(1, 0, 1, 20);
    chk("R8 up+mute ignored", stb_cnt, 0);
    chk("R8 level unchanged", level, 1);
  endtask

  task automatic t_standby;
    stb_cnt = 0;
    stby_n = 1'b0; wait_cyc(6);
    chk("R9 standby forces mute code", level, 32);
    press(0, 1, 0, 10);
    chk("R9 button ignored in standby", level, 32);
    chk("R9 strobe count in standby", stb_cnt, 1);
    stby_n = 1'b1; wait_cyc(6);
    chk("R9 standby release restores", level, 1);
    chk("R11 strobe on restore", stb_cnt, 2);
  endtask

  task automatic t_tick;
    stb_cnt = 0;
    tick = 1'b0;
    press(1, 0, 0, 40);
    chk("R12 no step without tick", stb_cnt, 0);
    chk("R12 level held", level, 1);
    tick = 1'b1;
    press(1, 0, 0, 10);
    chk("R12 step with tick", level, 0);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    t_reset();
    t_debounce();
    t_lockout();
    t_repeat();
    t_saturate();
    t_mute();
    t_chord();
    t_standby();
    t_tick();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule